// File: doc/BRIEF.md
# LE-Keyed Serial Command Front End

This block is the serial slave front end of a multi-channel LED driver. A host clocks 16-bit words in on a serial data line, most significant bit first, and marks each word with a window on a separate latch line. The number of serial clock rising edges seen while the latch line is high selects the command. The block loads a switch word, a configuration word, or a double-buffered bank of per-channel brightness words. It also raises one-cycle strobes for a diagnostic engine elsewhere in the chip.

Because brightness words pass through a staging chain, a full frame of channel values can be streamed in without disturbing the active values. A single global-latch key then commits the whole frame at once. The serial output carries the shift register's top bit, so several devices can be chained. A read key loads the configuration word or a diagnostic result word into the shift register so it can be clocked out. One configuration bit moves serial output changes onto the falling serial clock edge for cascaded parts.

All serial inputs are assumed to be already synchronised to the system clock. The system clock must run at least twice as fast as the serial clock, so that every serial edge is seen.

Top module: `lek_front`

## Requirements
- R1: At every rising serial clock edge, the serial data bit enters bit 0 of a 16-bit shift register, and the older bits move one place toward bit 15. Words are therefore sent most significant bit first.
- R2: Rising serial edges are counted only while the latch line is high. The count is decoded when the latch line falls, and it restarts from zero for the next window.
- R3: A count of 1 or 2 copies the shift register into the switch word.
- R4: A count of 3 or 4 pushes the shift register into the staging chain. It leaves every active brightness word unchanged.
- R5: A count of 5 or 6 writes the shift register to channel 0 and, in the same cycle, moves every staged word into the active bank. The first word pushed after the previous commit lands on channel 15, and the last word pushed lands on channel 1.
- R6: A count of 7 copies the shift register into the configuration word, which resets to 0x0000.
- R7: A count of 8 loads the configuration word into the shift register. Its bits then appear on the serial output over the next 16 serial clock pulses, bit 15 first.
- R8: Counts of 9, 10, 11, 12 and 13 each give a one-cycle pulse on, respectively, the open, short, combined, end and thermal strobes. At most one strobe is high in any cycle. Counts 12 and 13 also load the diagnostic input word into the shift register for read-out, bit 15 first.
- R9: A latch window with a count of 0, 14, 15 or 16 changes no register and raises no strobe.
- R10: With configuration bit 13 clear, the serial output equals shift register bit 15. A word shifted in therefore reappears on the output, bit 15 first, over the next 16 serial clock pulses.
- R11: With configuration bit 13 set, the serial output changes only at falling serial edges. After each falling edge it shows the bit that left bit 15 at the preceding rising edge.
- R12: Bits clocked in while the latch line is high are part of the word that the command acts on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock, synchronised |
| sdi_i | input | 1 | Serial data in |
| le_i | input | 1 | Latch line; its high window carries the command key |
| diag_i | input | 16 | Diagnostic result word, read out by the end and thermal keys |
| sdo_o | output | 1 | Serial data out |
| cfg_o | output | 16 | Configuration word |
| sw_o | output | 16 | Channel switch word |
| bright_o | output | 256 | Active brightness words, channel n at bits [16n+15:16n] |
| chk_open_o | output | 1 | Start-open-check strobe |
| chk_short_o | output | 1 | Start-short-check strobe |
| chk_both_o | output | 1 | Start-combined-check strobe |
| chk_end_o | output | 1 | End-detection strobe |
| therm_rd_o | output | 1 | Thermal-read strobe |

## Verification
The assertions check several rules on every cycle:
- each rising serial edge shifts in exactly one bit;
- the edge count is zero whenever the latch line is low;
- the strobes are one-hot and last a single cycle;
- a push leaves the active bank untouched, and a commit places the current word on channel 0;
- a configuration write takes the current word;
- the retimed output holds between falling edges.

Only the bench's scenarios can show the rest:
- the full key-to-command mapping, including the ignored counts;
- the channel order after a frame of pushes and a commit;
- the bit order of configuration and diagnostic read-out in both output timing modes;
- the 16-pulse pass-through used for chaining.

// File: rtl/lek_pkg.sv
// Package lek_pkg
// Shared command type and the key-count decoding used by the serial front end.
// Assumes key counts fit in 32 bits.
package lek_pkg;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_SW,
        CMD_BPUSH,
        CMD_BCOMMIT,
        CMD_CFGW,
        CMD_CFGR,
        CMD_OPEN,
        CMD_SHORT,
        CMD_BOTH,
        CMD_END,
        CMD_THERM
    } cmd_e;

    // Map a count of rising serial edges seen in the latch window to a command
    function automatic cmd_e key_to_cmd(input int unsigned n);
        case (n)
            1, 2:    return CMD_SW;
            3, 4:    return CMD_BPUSH;
            5, 6:    return CMD_BCOMMIT;
            7:       return CMD_CFGW;
            8:       return CMD_CFGR;
            9:       return CMD_OPEN;
            10:      return CMD_SHORT;
            11:      return CMD_BOTH;
            12:      return CMD_END;
            13:      return CMD_THERM;
            default: return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lek_key_decode.sv
// Module lek_key_decode
// Recovers serial clock edges from the synchronised serial clock, counts the
// rising edges inside each latch-high window, and issues one command in the
// cycle the latch line falls.
// Assumes sclk_i and le_i are synchronous to clk, and that clk runs at least
// twice the serial clock rate.
module lek_key_decode
    import lek_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic le_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output cmd_e cmd_o
);

    logic             sclk_q;
    logic             le_q;
    logic [CNT_W-1:0] cnt_q;
    logic             le_fall;

    // Hold the previous serial clock and latch levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            le_q   <= le_i;
        end
    end

    assign sclk_rise_o = sclk_i & ~sclk_q;
    assign sclk_fall_o = ~sclk_i & sclk_q;
    assign le_fall     = le_q & ~le_i;

    // Count rising serial edges while the latch is high, saturating at all ones
    always_ff @(posedge clk) begin
        if (!rst_n || !le_i) begin
            cnt_q <= '0;
        end else if (sclk_rise_o && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Decode the finished count in the cycle the latch line falls
    always_comb begin
        cmd_o = CMD_NONE;
        if (le_fall) begin
            cmd_o = key_to_cmd({{(32-CNT_W){1'b0}}, cnt_q});
        end
    end

    // R2: the count is empty whenever the latch line was low
    p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !le_i |=> (cnt_q == '0));

    // R2: a rising serial edge inside the window advances the count by one
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (le_i && sclk_rise_o && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lek_shifter.sv
// Module lek_shifter
// Serial input shift register with parallel load for read-out, plus the serial
// output stage with an optional falling-edge retime for cascaded devices.
// Assumes rise and fall are single-cycle edge pulses that never coincide.
module lek_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         sdi_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         retime_i,
    output logic [W-1:0] word_o,
    output logic         sdo_o
);

    logic [W-1:0] sr_q;
    logic         out_bit_q;
    logic         sdo_q;

    // Shift in MSB first on each rising serial edge; a read key reloads the register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= load_val_i;
        end else if (rise_i) begin
            sr_q <= {sr_q[W-2:0], sdi_i};
        end
    end

    // Remember the bit that left the top of the register at the last rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bit_q <= 1'b0;
        end else if (rise_i) begin
            out_bit_q <= sr_q[W-1];
        end
    end

    // Present that bit at the following falling edge for the retimed output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else if (fall_i) begin
            sdo_q <= out_bit_q;
        end
    end

    assign word_o = sr_q;
    assign sdo_o  = retime_i ? sdo_q : sr_q[W-1];

    // R1: one rising edge shifts exactly one data bit in at the bottom
    p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !load_i) |=> ((sr_q[0] == $past(sdi_i)) && (sr_q[W-1:1] == $past(sr_q[W-2:0]))));

    // R11: in retime mode the serial output moves only on a falling edge
    p_retime_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (retime_i && !fall_i) |=> (!retime_i || $stable(sdo_o)));

endmodule

// File: rtl/lek_bright_bank.sv
// Module lek_bright_bank
// Double-buffered brightness storage: a staging chain fed one word per push,
// and an active bank committed all at once. The commit word goes to channel 0
// and stage k goes to channel k+1.
// Assumes NCH is at least 2.
module lek_bright_bank #(
    parameter int NCH = 16,
    parameter int W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             commit_i,
    input  logic [W-1:0]     word_i,
    output logic [NCH*W-1:0] bright_o
);

    localparam int NSTG = NCH - 1;

    logic [W-1:0] stage_q [NSTG];
    logic [W-1:0] act_q   [NCH];

    // Entry of the staging chain takes the pushed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else if (push_i) begin
            stage_q[0] <= word_i;
        end
    end

    // Channel 0 of the active bank takes the commit word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q[0] <= '0;
        end else if (commit_i) begin
            act_q[0] <= word_i;
        end
    end

    assign bright_o[W-1:0] = act_q[0];

    for (genvar g = 1; g < NSTG; g++) begin : g_stage
        // Each later stage takes the word of the stage before it on a push
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (push_i) begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    for (genvar c = 1; c < NCH; c++) begin : g_act
        // Each higher channel takes its staged word on a commit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q[c] <= '0;
            end else if (commit_i) begin
                act_q[c] <= stage_q[c-1];
            end
        end
        assign bright_o[c*W +: W] = act_q[c];
    end

    // R4: a push alone never disturbs the active brightness words
    p_push_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !commit_i) |=> $stable(bright_o));

    // R5: a commit puts the current word on channel 0
    p_commit_ch0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (bright_o[W-1:0] == $past(word_i)));

endmodule

// File: rtl/lek_front.sv
// Module lek_front
// Top of the latch-keyed serial command front end: key decoding, shift
// register with serial output, configuration and switch words, brightness bank
// and diagnostic strobes.
// Assumes all serial inputs are synchronised to clk; reset is synchronous, active low.
module lek_front
    import lek_pkg::*;
#(
    parameter int W          = 16,
    parameter int NCH        = 16,
    parameter int RETIME_BIT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sdi_i,
    input  logic             le_i,
    input  logic [W-1:0]     diag_i,
    output logic             sdo_o,
    output logic [W-1:0]     cfg_o,
    output logic [W-1:0]     sw_o,
    output logic [NCH*W-1:0] bright_o,
    output logic             chk_open_o,
    output logic             chk_short_o,
    output logic             chk_both_o,
    output logic             chk_end_o,
    output logic             therm_rd_o
);

    localparam int CNT_W = $clog2(W + 1);

    logic         rise;
    logic         fall;
    cmd_e         cmd;
    logic [W-1:0] word;
    logic         load;
    logic [W-1:0] load_val;
    logic [W-1:0] cfg_q;
    logic [W-1:0] sw_q;

    lek_key_decode #(.CNT_W(CNT_W)) i_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_i),
        .le_i        (le_i),
        .sclk_rise_o (rise),
        .sclk_fall_o (fall),
        .cmd_o       (cmd)
    );

    // Pick the word placed in the shift register by a read key
    always_comb begin
        load     = 1'b0;
        load_val = cfg_q;
        case (cmd)
            CMD_CFGR:           load = 1'b1;
            CMD_END, CMD_THERM: begin
                load     = 1'b1;
                load_val = diag_i;
            end
            default:            load = 1'b0;
        endcase
    end

    lek_shifter #(.W(W)) i_sh (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .fall_i     (fall),
        .sdi_i      (sdi_i),
        .load_i     (load),
        .load_val_i (load_val),
        .retime_i   (cfg_q[RETIME_BIT]),
        .word_o     (word),
        .sdo_o      (sdo_o)
    );

    lek_bright_bank #(.NCH(NCH), .W(W)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (cmd == CMD_BPUSH),
        .commit_i (cmd == CMD_BCOMMIT),
        .word_i   (word),
        .bright_o (bright_o)
    );

    // Configuration and switch words take the shifted word on their keys
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            sw_q  <= '0;
        end else begin
            if (cmd == CMD_CFGW) cfg_q <= word;
            if (cmd == CMD_SW)   sw_q  <= word;
        end
    end

    // Register the diagnostic strobes as single-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_open_o  <= 1'b0;
            chk_short_o <= 1'b0;
            chk_both_o  <= 1'b0;
            chk_end_o   <= 1'b0;
            therm_rd_o  <= 1'b0;
        end else begin
            chk_open_o  <= (cmd == CMD_OPEN);
            chk_short_o <= (cmd == CMD_SHORT);
            chk_both_o  <= (cmd == CMD_BOTH);
            chk_end_o   <= (cmd == CMD_END);
            therm_rd_o  <= (cmd == CMD_THERM);
        end
    end

    assign cfg_o = cfg_q;
    assign sw_o  = sw_q;

    // R6: a configuration key stores the current shift word
    p_cfg_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CFGW) |=> (cfg_o == $past(word)));

    // R8: never more than one diagnostic strobe at a time
    p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chk_open_o, chk_short_o, chk_both_o, chk_end_o, therm_rd_o}));

    // R8: each strobe lasts exactly one cycle
    p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_open_o || chk_short_o || chk_both_o || chk_end_o || therm_rd_o)
        |=> !(chk_open_o || chk_short_o || chk_both_o || chk_end_o || therm_rd_o));

    // R9: with no decoded command, the configuration and switch words hold
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NONE) |=> ($stable(cfg_o) && $stable(sw_o)));

endmodule

// File: tb/test_lek_front.sv
// Bench test_lek_front: drives serial words with latch keys and compares
// every output against a model computed in the bench.
module test_lek_front;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int NCH        = 16;
    localparam logic [15:0] DIAG = 16'hC3A5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sclk = 1'b0;
    logic             sdi = 1'b0;
    logic             le = 1'b0;
    logic [W-1:0]     diag = DIAG;
    logic             sdo;
    logic [W-1:0]     cfg;
    logic [W-1:0]     sw;
    logic [NCH*W-1:0] bright;
    logic             s_open, s_short, s_both, s_end, s_therm;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int n_open = 0, n_short = 0, n_both = 0, n_end = 0, n_therm = 0;

    logic [15:0] m_cfg = '0;
    logic [15:0] m_sw  = '0;
    logic [15:0] m_stage [NCH-1];
    logic [15:0] m_act   [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    lek_front i_lek_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .sdi_i       (sdi),
        .le_i        (le),
        .diag_i      (diag),
        .sdo_o       (sdo),
        .cfg_o       (cfg),
        .sw_o        (sw),
        .bright_o    (bright),
        .chk_open_o  (s_open),
        .chk_short_o (s_short),
        .chk_both_o  (s_both),
        .chk_end_o   (s_end),
        .therm_rd_o  (s_therm)
    );

    // Count strobe pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_open  += int'(s_open);
            n_short += int'(s_short);
            n_both  += int'(s_both);
            n_end   += int'(s_end);
            n_therm += int'(s_therm);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic l);
        @(negedge clk);
        sdi = b; le = l; sclk = 1'b0;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    // Send one word; the last `key` bits are clocked with the latch line high
    task automatic send_word(input logic [15:0] w, input int key);
        for (int i = 0; i < 16; i++) send_bit(w[15-i], (i >= 16 - key));
        if (key == 0) begin
            @(negedge clk); le = 1'b1;
            repeat (2) @(negedge clk);
        end
        @(negedge clk); le = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Clock out 16 bits and compare the serial output, bit 15 first
    task automatic read_seq(input logic [15:0] exp, input bit retime, input string req);
        for (int k = 0; k < 16; k++) begin
            if (!retime) chk(sdo == exp[15-k], req, 32'(sdo), 32'(exp[15-k]));
            send_bit(1'b0, 1'b0);
            if (retime) chk(sdo == exp[15-k], req, 32'(sdo), 32'(exp[15-k]));
        end
    endtask

    task automatic chk_bank(input string req);
        for (int c = 0; c < NCH; c++)
            chk(bright[c*W +: W] == m_act[c], req, 32'(bright[c*W +: W]), 32'(m_act[c]));
    endtask

    task automatic chk_regs(input string req);
        chk(cfg == m_cfg, req, 32'(cfg), 32'(m_cfg));
        chk(sw == m_sw, req, 32'(sw), 32'(m_sw));
        chk_bank(req);
    endtask

    // Stream one frame of brightness words (channel 15 first) and commit it
    task automatic frame(input int round, input int push_key, input int commit_key);
        logic [15:0] v;
        for (int c = NCH - 1; c >= 1; c--) begin
            v = 16'(round * 16'h1357) ^ 16'(c * 16'h0911);
            send_word(v, push_key);
            for (int s = NCH - 2; s >= 1; s--) m_stage[s] = m_stage[s-1];
            m_stage[0] = v;
        end
        chk_bank("R4");
        v = 16'(round * 16'h1357) ^ 16'hBEEF;
        send_word(v, commit_key);
        m_act[0] = v;
        for (int c = 1; c < NCH; c++) m_act[c] = m_stage[c-1];
        chk_bank("R5");
    endtask

    initial begin
        for (int i = 0; i < NCH - 1; i++) m_stage[i] = '0;
        for (int i = 0; i < NCH; i++) m_act[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset state
        chk_regs("R6");
        chk(sdo == 1'b0, "R10", 32'(sdo), 32'h0);
        chk({s_open, s_short, s_both, s_end, s_therm} == 5'b0, "R8", 32'(s_open), 32'h0);

        // R6 / R12: configuration write with the key bits part of the word
        send_word(16'h1234, 7); m_cfg = 16'h1234;
        chk(cfg == m_cfg, "R6", 32'(cfg), 32'(m_cfg));
        send_word(16'h007F, 7); m_cfg = 16'h007F;
        chk(cfg == m_cfg, "R12", 32'(cfg), 32'(m_cfg));
        send_word(16'h1234, 7); m_cfg = 16'h1234;

        // R7: configuration read-out
        send_word(16'h0000, 8);
        read_seq(m_cfg, 1'b0, "R7");

        // R3: switch write with both key counts
        send_word(16'hA55A, 1); m_sw = 16'hA55A;
        chk(sw == m_sw, "R3", 32'(sw), 32'(m_sw));
        send_word(16'h0FF1, 2); m_sw = 16'h0FF1;
        chk(sw == m_sw, "R3", 32'(sw), 32'(m_sw));

        // R4 / R5: two full frames with the alternate keys
        frame(1, 3, 5);
        frame(2, 4, 6);

        // R9: ignored counts change nothing and raise no strobe
        send_word(16'hFFFF, 0);
        send_word(16'hFFFF, 14);
        send_word(16'hFFFF, 15);
        send_word(16'hFFFF, 16);
        chk_regs("R9");
        chk(n_open + n_short + n_both + n_end + n_therm == 0, "R9",
            32'(n_open + n_short + n_both + n_end + n_therm), 32'h0);

        // R8: diagnostic strobes
        send_word(16'h0000, 9);
        chk(n_open == 1, "R8", 32'(n_open), 32'h1);
        send_word(16'h0000, 10);
        chk(n_short == 1, "R8", 32'(n_short), 32'h1);
        send_word(16'h0000, 11);
        chk(n_both == 1, "R8", 32'(n_both), 32'h1);
        send_word(16'h0000, 12);
        chk(n_end == 1, "R8", 32'(n_end), 32'h1);
        read_seq(DIAG, 1'b0, "R8");
        send_word(16'h0000, 13);
        chk(n_therm == 1, "R8", 32'(n_therm), 32'h1);
        read_seq(DIAG, 1'b0, "R8");
        chk(n_open + n_short + n_both == 3, "R8", 32'(n_open + n_short + n_both), 32'h3);
        chk_regs("R8");

        // R10: pass-through of a plain word
        send_word(16'h9C31, 0);
        read_seq(16'h9C31, 1'b0, "R10");

        // R11: retimed output for read-out and pass-through
        send_word(16'hA5C3, 7); m_cfg = 16'hA5C3;
        chk(cfg == m_cfg, "R11", 32'(cfg), 32'(m_cfg));
        send_word(16'h0000, 8);
        read_seq(m_cfg, 1'b1, "R11");
        send_word(16'h6E0D, 0);
        read_seq(16'h6E0D, 1'b1, "R11");

        // R1: words are taken MSB first, checked through a switch write
        send_word(16'h8001, 1); m_sw = 16'h8001;
        chk(sw == m_sw, "R1", 32'(sw), 32'(m_sw));
        // R2: the count restarts for each window
        send_word(16'h4002, 2); m_sw = 16'h4002;
        chk(sw == m_sw, "R2", 32'(sw), 32'(m_sw));
        chk(cfg == m_cfg, "R2", 32'(cfg), 32'(m_cfg));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule